// File: doc/BRIEF.md
# Registered Sum-of-Products Macrocell Array

A small programmable logic device. A programmable AND plane forms product terms from any true or complemented data input and from the true or complemented state of every output register. A fixed OR plane collects a fixed group of product terms for each output. Each output macrocell can invert its sum and can route it either through a flip-flop or straight to the pin. The register state is fed back into the AND plane, so the array can hold state machines as well as plain combinational functions.

The personality is a flat vector of fuse bits, loaded one word at a time through a parallel configuration port. Loading is allowed only while the device is held in its configuration mode. In that mode the registers are kept at 0 and the outputs are quiet. When the mode is released, the array runs from the loaded pattern on a single rising-edge clock.

Top module: `pal_array`

## Requirements
- R1: A synchronous active-high `rst` clears every fuse bit and every macrocell register. Afterwards all outputs read 0, and they stay 0 on further clocks until a new pattern is loaded.
- R2: While `cfg_mode`=1 and `cfg_we`=1, a rising edge writes `cfg_wdata` into fuse bits [16*a+15 : 16*a], where a is `cfg_addr`. Addresses 193 and above are ignored.
- R3: While `cfg_mode`=1, every `data_out` bit reads 0, and each rising edge leaves every macrocell register at 0.
- R4: A `cfg_we` pulse while `cfg_mode`=0 leaves the fuse pattern unchanged.
- R5: Product term p of output o is the AND of the literals whose fuse is set. The fuse index is ((o*8+p)*24+v)*2+n. Variable v<16 is `data_in[v]`, and v=16+k is the state of register k. n=0 selects the true form and n=1 the complement. A term with no fuse set is 0.
- R6: The sum of output o is the OR of its 8 product terms.
- R7: Fuse 3072+2*o set inverts the sum of output o.
- R8: Fuse 3073+2*o set makes output o combinational: `data_out[o]` follows the polarity-adjusted sum in the same cycle.
- R9: Fuse 3073+2*o clear makes output o registered. Its register takes the polarity-adjusted sum on each rising edge, and `data_out[o]` shows the register.
- R10: Through register feedback, the array can run a 3-bit counter with an enable taken from `data_in[0]`. The counter wraps from 7 to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock for the registers and the fuse store |
| rst | input | 1 | Synchronous reset, active high |
| cfg_mode | input | 1 | 1 holds the device idle and opens the configuration port |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 16 | Configuration word data |
| data_in | input | 16 | Array input variables |
| data_out | output | 8 | Macrocell outputs |

## Verification
Combinational outputs respond within the same cycle. The bench changes data inputs on the falling edge and samples two nanoseconds later, before the next rising edge. Registered outputs and counter states are due one rising edge after the inputs that produce them, so the bench samples them on the following falling edge and compares them with a count it advances only for edges where the enable was high. Fuse writes take effect on the edge that samples the strobe, and every pattern is fully loaded before `cfg_mode` is released.

// File: rtl/pal_pkg.sv
package pal_pkg;

    // Per-output macrocell personality; inv sits in the lower fuse bit.
    typedef struct packed {
        logic comb;  // 1: bypass the flip-flop
        logic inv;   // 1: invert the OR sum
    } mc_mode_t;

endpackage

// File: rtl/pal_fuse_store.sv
module pal_fuse_store #(
    parameter int FUSE_N = 3088,
    parameter int CFG_W  = 16,
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [FUSE_N-1:0] fuse_q
);
    localparam int WORD_N  = (FUSE_N + CFG_W - 1) / CFG_W;
    localparam int STORE_N = WORD_N * CFG_W;

    logic [STORE_N-1:0] store_d;
    logic [STORE_N-1:0] store_q;

    always_comb begin
        store_d = store_q;
        if (cfg_mode && cfg_we) begin
            for (int w = 0; w < WORD_N; w++) begin
                if (cfg_addr == CFG_AW'(w)) begin
                    store_d[w*CFG_W +: CFG_W] = cfg_wdata;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            store_q <= '0;
        end else begin
            store_q <= store_d;
        end
    end

    assign fuse_q = store_q[FUSE_N-1:0];
endmodule

// File: rtl/pal_and_plane.sv
module pal_and_plane #(
    parameter int VAR_N  = 24,
    parameter int TERM_N = 64
) (
    input  logic [VAR_N-1:0]          vars,
    input  logic [TERM_N*2*VAR_N-1:0] masks,
    output logic [TERM_N-1:0]         terms
);
    localparam int LIT_N = 2 * VAR_N;

    logic [LIT_N-1:0] lits;

    // Each variable appears twice: true form, then complement.
    for (genvar v = 0; v < VAR_N; v++) begin : g_lit
        assign lits[2*v]     = vars[v];
        assign lits[2*v + 1] = ~vars[v];
    end

    for (genvar t = 0; t < TERM_N; t++) begin : g_term
        logic [LIT_N-1:0] mask;
        assign mask = masks[t*LIT_N +: LIT_N];
        // A term with no connection reads 0 rather than a vacuous 1.
        assign terms[t] = (|mask) & (&(lits | ~mask));
    end
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
    import pal_pkg::*;
#(
    parameter int PT_N = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic [PT_N-1:0] terms,
    input  mc_mode_t        mode,
    output logic            sum_pol,
    output logic            state_q,
    output logic            pin
);
    logic state_d;

    always_comb begin
        sum_pol = (|terms) ^ mode.inv;
        state_d = hold ? 1'b0 : sum_pol;
        if (hold) begin
            pin = 1'b0;
        end else if (mode.comb) begin
            pin = sum_pol;
        end else begin
            pin = state_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end
endmodule

// File: rtl/pal_array.sv
module pal_array
    import pal_pkg::*;
#(
    parameter int IN_N   = 16,
    parameter int OUT_N  = 8,
    parameter int PT_N   = 8,
    parameter int CFG_W  = 16,
    parameter int CFG_AW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_mode,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic [IN_N-1:0]   data_in,
    output logic [OUT_N-1:0]  data_out
);
    localparam int VAR_N      = IN_N + OUT_N;
    localparam int LIT_N      = 2 * VAR_N;
    localparam int TERM_N     = OUT_N * PT_N;
    localparam int ARRAY_BITS = TERM_N * LIT_N;
    localparam int FUSE_N     = ARRAY_BITS + 2 * OUT_N;

    logic [FUSE_N-1:0] fuse_bits;
    logic [VAR_N-1:0]  array_vars;
    logic [TERM_N-1:0] terms;
    logic [OUT_N-1:0]  mc_state;
    logic [OUT_N-1:0]  mc_sum;

    pal_fuse_store #(
        .FUSE_N (FUSE_N),
        .CFG_W  (CFG_W),
        .CFG_AW (CFG_AW)
    ) u_fuse (
        .clk       (clk),
        .rst       (rst),
        .cfg_mode  (cfg_mode),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .fuse_q    (fuse_bits)
    );

    // Inputs occupy the low variable slots, register feedback the high ones.
    assign array_vars = {mc_state, data_in};

    pal_and_plane #(
        .VAR_N  (VAR_N),
        .TERM_N (TERM_N)
    ) u_and (
        .vars  (array_vars),
        .masks (fuse_bits[ARRAY_BITS-1:0]),
        .terms (terms)
    );

    for (genvar o = 0; o < OUT_N; o++) begin : g_mc
        pal_macrocell #(
            .PT_N (PT_N)
        ) u_mc (
            .clk     (clk),
            .rst     (rst),
            .hold    (cfg_mode),
            .terms   (terms[o*PT_N +: PT_N]),
            .mode    (mc_mode_t'(fuse_bits[ARRAY_BITS + 2*o +: 2])),
            .sum_pol (mc_sum[o]),
            .state_q (mc_state[o]),
            .pin     (data_out[o])
        );
    end
endmodule

// File: rtl/pal_array_checker.sv
module pal_array_checker #(
    parameter int FUSE_N = 3088,
    parameter int OUT_N  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cfg_mode,
    input logic              cfg_we,
    input logic [FUSE_N-1:0] fuse_bits,
    input logic [OUT_N-1:0]  mc_state,
    input logic [OUT_N-1:0]  mc_sum,
    input logic [OUT_N-1:0]  data_out
);
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (mc_state == '0 && fuse_bits == '0));

    assert_idle_regs_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |=> mc_state == '0);

    assert_idle_pins_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_mode |-> data_out == '0);

    assert_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(fuse_bits));

    assert_locked_fuses_R4: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> $stable(fuse_bits));

    assert_reg_capture_R9: assert property (@(posedge clk) disable iff (rst)
        !cfg_mode |=> mc_state == $past(mc_sum));
endmodule

bind pal_array pal_array_checker #(
    .FUSE_N (FUSE_N),
    .OUT_N  (OUT_N)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_mode  (cfg_mode),
    .cfg_we    (cfg_we),
    .fuse_bits (fuse_bits),
    .mc_state  (mc_state),
    .mc_sum    (mc_sum),
    .data_out  (data_out)
);

// File: tb/pal_array_bench.sv
module pal_array_bench;
    localparam int VAR_N = 24;
    localparam int ARRAY = 3072;
    localparam int FUSES = 3088;
    localparam int WORDS = 193;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_mode = 1'b1;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] data_in = '0;
    logic [7:0]  data_out;

    int checks = 0;
    int errors = 0;
    logic [FUSES-1:0] fz;

    always #4 clk = ~clk;

    pal_array u_pal_array (
        .clk       (clk),
        .rst       (rst),
        .cfg_mode  (cfg_mode),
        .cfg_we    (cfg_we),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .data_in   (data_in),
        .data_out  (data_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: data_out=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic lit(input int o, input int p, input int v, input int n);
        fz[((o*8 + p)*VAR_N + v)*2 + n] = 1'b1;
    endtask

    task automatic mc(input int o, input bit inv, input bit comb);
        fz[ARRAY + 2*o]     = inv;
        fz[ARRAY + 2*o + 1] = comb;
    endtask

    // Loads fz word by word; leaves cfg_mode high.
    task automatic load();
        @(negedge clk);
        cfg_mode = 1'b1;
        for (int w = 0; w < WORDS; w++) begin
            cfg_we = 1'b1;
            cfg_addr = 8'(w);
            cfg_wdata = fz[w*16 +: 16];
            @(negedge clk);
        end
        cfg_we = 1'b0;
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog: data_out=%h expected=done", data_out);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] cnt;
        logic       en;
        logic [7:0] exp;
        repeat (3) @(negedge clk);
        check("R1 reset", data_out, 8'h00);
        rst = 1'b0;
        cfg_mode = 1'b0;

        // R5: blank fuses, registered outputs stay 0 whatever the inputs.
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            data_in = 16'(i * 4369);
            @(negedge clk);
            check("R5 empty terms", data_out, 8'h00);
        end

        // R7: no terms, inverted, combinational -> all ones.
        fz = '0;
        for (int o = 0; o < 8; o++) mc(o, 1'b1, 1'b1);
        load();
        check("R3 idle pins", data_out, 8'h00);
        cfg_mode = 1'b0;
        #2 check("R7 inverted empty sum", data_out, 8'hFF);

        // R8/R7/R5: 3-to-8 decoder, upper half active low.
        fz = '0;
        for (int o = 0; o < 8; o++) begin
            mc(o, o >= 4, 1'b1);
            for (int b = 0; b < 3; b++) lit(o, 0, b, ((o >> b) & 1) ? 0 : 1);
        end
        load();
        cfg_mode = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            data_in = {13'(i * 37), 3'(i)};
            exp = (8'h01 << (i % 8)) ^ 8'hF0;
            #2 check("R8 decoder", data_out, exp);
        end

        // R6: out[o] = in[8+o] & |in[7:0], one term per low input.
        fz = '0;
        for (int o = 0; o < 8; o++) begin
            mc(o, 1'b0, 1'b1);
            for (int p = 0; p < 8; p++) begin
                lit(o, p, p, 0);
                lit(o, p, 8 + o, 0);
            end
        end
        load();
        cfg_mode = 1'b0;
        for (int i = 0; i < 1024; i++) begin
            @(negedge clk);
            data_in = 16'(i * 613) ^ 16'(i << 5);
            exp = (|data_in[7:0]) ? data_in[15:8] : 8'h00;
            #2 check("R6 sum of terms", data_out, exp);
        end

        // R9/R10: counter with enable on in[0].
        fz = '0;
        lit(0, 0, 16, 0); lit(0, 0, 0, 1);
        lit(0, 1, 16, 1); lit(0, 1, 0, 0);
        lit(1, 0, 17, 0); lit(1, 0, 0, 1);
        lit(1, 1, 17, 0); lit(1, 1, 16, 1);
        lit(1, 2, 17, 1); lit(1, 2, 16, 0); lit(1, 2, 0, 0);
        lit(2, 0, 18, 0); lit(2, 0, 0, 1);
        lit(2, 1, 18, 0); lit(2, 1, 17, 1);
        lit(2, 2, 18, 0); lit(2, 2, 16, 1);
        lit(2, 3, 18, 1); lit(2, 3, 17, 0); lit(2, 3, 16, 0); lit(2, 3, 0, 0);
        mc(3, 1'b1, 1'b0);
        lit(4, 0, 16, 1); lit(4, 1, 16, 0); lit(4, 1, 16, 1);
        mc(4, 1'b0, 1'b1);
        lit(5, 0, 1, 0);
        mc(5, 1'b1, 1'b1);
        load();
        // R2: out-of-range address must not disturb the pattern.
        cfg_we = 1'b1; cfg_addr = 8'd200; cfg_wdata = 16'hFFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        check("R3 idle during load", data_out, 8'h00);
        cnt = '0;
        en = 1'b1;
        data_in = 16'h0001;
        cfg_mode = 1'b0;
        for (int k = 0; k < 28; k++) begin
            @(negedge clk);
            if (en) cnt = cnt + 3'd1;
            exp = {2'b00, ~data_in[1], ~cnt[0], 1'b1, cnt};
            check("R10 counter R9 R2 R4", data_out, exp);
            en = (k % 5) != 3;
            data_in = {14'(k * 91), k[0], en};
            // R4: a write strobe outside configuration mode.
            cfg_we = (k == 10);
            cfg_addr = 8'd0;
            cfg_wdata = 16'h0000;
        end
        cfg_we = 1'b0;

        // R3: entering configuration mode clears the registers.
        cfg_mode = 1'b1;
        @(negedge clk);
        check("R3 idle", data_out, 8'h00);
        cfg_mode = 1'b0;
        data_in = 16'h0000;
        @(negedge clk);
        check("R9 restart from zero", data_out, {2'b00, 1'b1, 1'b1, 1'b1, 3'd0});

        // R1: reset mid-run wipes fuses and registers.
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1 reset output", data_out, 8'h00);
        data_in = 16'h0003;
        repeat (3) @(negedge clk);
        check("R1 fuses cleared", data_out, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule